// File: doc/BRIEF.md
# Tick-Driven Coil Command and Barrier Sample Sequencer

This block drives a row of seven electromagnet coils from a queue of commands and records a six-bit light-barrier word. A host fills the command queue before and during a run. After a start strobe, a divider produces one sample tick every `CLK_HZ / TICK_HZ` clock cycles (38.4 kHz by default). On each tick the block does two things at once. It takes the oldest command, decodes it to at most one active coil, and drives that coil. It also stores the current barrier word in a second queue, which the host empties at its own pace.

The host reaches the block through plain strobes. Each of the write, read, start and stop strobes passes through a two-flop synchronizer and acts once, on its rising edge. The strobe interface has no ready signal, so back-pressure works through flags. The host must watch `mag_full` before writing, because a write into a full command queue is dropped. It must watch `sns_empty` before reading, because a read from an empty sample queue leaves `host_rd_data` unchanged.

The block latches `fault` in three cases: a tick finds the command queue empty, a tick pops a reserved command code, or a sample arrives while the sample queue is full. Once latched, `fault` stays set and holds all coils off until reset.

Top module: `coil_sample_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, both queues are empty (`mag_empty`=1, `sns_empty`=1, `mag_full`=`sns_full`=`sns_half`=0), `coil_en`=0, `running`=0 and `fault`=0.
- R2: Ticks occur only while `running` is high. The first tick takes effect DIV = CLK_HZ/TICK_HZ cycles after `running` rises, and each later tick DIV cycles after the one before. Before a start strobe, no command is consumed.
- R3: On a tick, the oldest command is popped and applied to `coil_en` at that tick edge. Code 0x00 turns all coils off. Code 2*k (k = 1..7, so 0x02 to 0x0E) turns on `coil_en[k-1]` only, where bit 0 is the top coil and bit 6 is the bottom coil.
- R4: `coil_en` never has more than one bit set.
- R5: A popped code that is odd or above 0x0E turns all coils off and sets `fault` on the same tick edge.
- R6: A tick that finds the command queue empty sets `fault` on that tick edge.
- R7: `fault` stays set until reset, and `coil_en` is 0 whenever `fault` is 1, even when later commands are valid.
- R8: Each tick stores `barrier_in` in the sample queue. Bit b holds barrier b+1, with barrier 1 at the top, and a 1 means the barrier is unobstructed. Host reads return the samples in the order they were taken.
- R9: `sns_half` is 1 when the sample queue holds at least half its depth, and `sns_full` is 1 when it holds its full depth. A sample that arrives while the queue is full is dropped and sets `fault`.
- R10: A rising edge on `host_wr_stb` pushes `host_wr_data` exactly once, however long the strobe is held high. `mag_full` is 1 when the command queue holds its full depth.
- R11: A stop strobe clears `running` and turns all coils off. After that, no command is popped and no sample is taken.
- R12: A read strobe while the sample queue is empty leaves `host_rd_data` and `sns_empty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low reset; clears both queues, the fault flag and the run state |
| host_wr_stb | input | 1 | Asynchronous strobe; its rising edge pushes one command |
| host_wr_data | input | 8 | Command code to push; must be held stable while the strobe is high |
| host_rd_stb | input | 1 | Asynchronous strobe; its rising edge pops one sample |
| host_rd_data | output | 6 | Last sample popped by the host |
| start_stb | input | 1 | Asynchronous strobe; its rising edge starts ticking |
| stop_stb | input | 1 | Asynchronous strobe; its rising edge stops ticking |
| barrier_in | input | 6 | Live light-barrier word, one bit per barrier |
| coil_en | output | 7 | One-hot coil enables; bit 0 is the top coil |
| running | output | 1 | Tick engine active |
| fault | output | 1 | Sticky run-failure flag |
| mag_empty | output | 1 | Command queue empty |
| mag_full | output | 1 | Command queue full |
| sns_empty | output | 1 | Sample queue empty |
| sns_full | output | 1 | Sample queue full |
| sns_half | output | 1 | Sample queue at least half full |

## Verification
The bench builds the block with CLK_HZ=384000 and TICK_HZ=38400, which gives a ten-cycle tick, so a whole run with its measured tick spacing takes a few hundred cycles. The command queue is 32 deep and the sample queue is 16 deep. With the sample queue shallower than the command queue, the sample queue overflows before the command queue runs dry, so the overflow fault and the dry-queue fault can be observed separately. Both the full and the half-full thresholds are reached within a couple of hundred cycles.

// File: rtl/coilseq_pkg.sv
package coilseq_pkg;
  localparam int CMD_W   = 8;
  localparam int N_COIL  = 7;
  localparam int N_BAR   = 6;
  localparam int N_STB   = 4;

  // strobe lane indices
  localparam int L_WR    = 0;
  localparam int L_RD    = 1;
  localparam int L_GO    = 2;
  localparam int L_HALT  = 3;

  typedef struct packed {
    logic              ok;
    logic [N_COIL-1:0] hot;
  } coil_dec_t;

  // even codes 0x00..0x0E are legal; 2*k selects coil k
  function automatic coil_dec_t coil_decode(input logic [CMD_W-1:0] code);
    coil_dec_t r;
    r.ok  = (code[0] == 1'b0) && (code <= CMD_W'(2 * N_COIL));
    r.hot = '0;
    for (int i = 0; i < N_COIL; i++) begin
      if (code == CMD_W'(2 * (i + 1))) r.hot[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_in,
  output logic pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], stb_in};
  end

  assign pulse = sh[1] & ~sh[2];
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (level != (AW+1)'(DEPTH));
  assign do_pop  = pop  && (level != '0);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 2604
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/coil_sample_seq.sv
module coil_sample_seq
  import coilseq_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 38_400,
  parameter int MAG_AW  = 8,
  parameter int SNS_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_stb,
  input  logic [CMD_W-1:0]  host_wr_data,
  input  logic              host_rd_stb,
  output logic [N_BAR-1:0]  host_rd_data,
  input  logic              start_stb,
  input  logic              stop_stb,
  input  logic [N_BAR-1:0]  barrier_in,
  output logic [N_COIL-1:0] coil_en,
  output logic              running,
  output logic              fault,
  output logic              mag_empty,
  output logic              mag_full,
  output logic              sns_empty,
  output logic              sns_full,
  output logic              sns_half
);
  localparam int DIV       = CLK_HZ / TICK_HZ;
  localparam int MAG_DEPTH = 1 << MAG_AW;
  localparam int SNS_DEPTH = 1 << SNS_AW;

  logic [N_STB-1:0] stb_raw, stb_p;
  assign stb_raw[L_WR]   = host_wr_stb;
  assign stb_raw[L_RD]   = host_rd_stb;
  assign stb_raw[L_GO]   = start_stb;
  assign stb_raw[L_HALT] = stop_stb;

  for (genvar g = 0; g < N_STB; g++) begin : g_sync
    strobe_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_in (stb_raw[g]),
      .pulse  (stb_p[g])
    );
  end

  logic               tick;
  logic               mag_pop;
  logic [CMD_W-1:0]   cmd_head;
  logic [MAG_AW:0]    mag_lvl;
  logic [N_BAR-1:0]   sns_head;
  logic [SNS_AW:0]    sns_lvl;
  logic               running_q, fault_q, fault_set;
  logic [N_COIL-1:0]  coil_q;
  logic [N_BAR-1:0]   rd_q;
  coil_dec_t          dec;

  tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running_q),
    .tick  (tick)
  );

  sync_fifo #(.W(CMD_W), .AW(MAG_AW)) u_mag (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stb_p[L_WR]),
    .din   (host_wr_data),
    .pop   (mag_pop),
    .head  (cmd_head),
    .level (mag_lvl)
  );

  sync_fifo #(.W(N_BAR), .AW(SNS_AW)) u_sns (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tick),
    .din   (barrier_in),
    .pop   (stb_p[L_RD]),
    .head  (sns_head),
    .level (sns_lvl)
  );

  assign mag_empty = (mag_lvl == '0);
  assign mag_full  = (mag_lvl == (MAG_AW+1)'(MAG_DEPTH));
  assign sns_empty = (sns_lvl == '0);
  assign sns_full  = (sns_lvl == (SNS_AW+1)'(SNS_DEPTH));
  assign sns_half  = (sns_lvl >= (SNS_AW+1)'(SNS_DEPTH / 2));

  assign mag_pop   = tick && !mag_empty;
  assign dec       = coil_decode(cmd_head);
  assign fault_set = tick && (mag_empty || !dec.ok || sns_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      fault_q   <= 1'b0;
      coil_q    <= '0;
      rd_q      <= '0;
    end else begin
      if (stb_p[L_HALT])    running_q <= 1'b0;
      else if (stb_p[L_GO]) running_q <= 1'b1;

      fault_q <= fault_q | fault_set;

      if (stb_p[L_HALT])            coil_q <= '0;
      else if (fault_q || fault_set) coil_q <= '0;
      else if (tick)                coil_q <= dec.hot;

      if (stb_p[L_RD] && !sns_empty) rd_q <= sns_head;
    end
  end

  assign running      = running_q;
  assign fault        = fault_q;
  assign coil_en      = coil_q;
  assign host_rd_data = rd_q;
endmodule

// File: rtl/coil_sample_seq_chk.sv
module coil_sample_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [6:0] coil_en,
  input logic       running,
  input logic       fault,
  input logic       mag_empty,
  input logic       sns_empty,
  input logic       sns_full,
  input logic       sns_half
);
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coil_en));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_fault_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (coil_en == 7'd0));

  p_dry_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mag_empty) |=> fault);

  p_full_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sns_full |-> (sns_half && !sns_empty));

  p_stop_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (coil_en == 7'd0));

  p_tick_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(coil_en) || (coil_en == 7'd0));
endmodule

bind coil_sample_seq coil_sample_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .coil_en   (coil_en),
  .running   (running),
  .fault     (fault),
  .mag_empty (mag_empty),
  .sns_empty (sns_empty),
  .sns_full  (sns_full),
  .sns_half  (sns_half)
);

// File: tb/sim_coil_sample_seq.sv
`timescale 1ns/1ps
module sim_coil_sample_seq;
  localparam int CLK_HZ  = 384_000;
  localparam int TICK_HZ = 38_400;
  localparam int DIV     = CLK_HZ / TICK_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0, rd_stb = 1'b0, go_stb = 1'b0, halt_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] bar_in = '0;
  logic [5:0] rd_data;
  logic [6:0] coil_en;
  logic       running, fault, mag_empty, mag_full, sns_empty, sns_full, sns_half;

  int total = 0, bad = 0;
  int cyc = 0;
  int last_chg = 0, run_t = 0, fault_t = 0, sidx = 0;
  logic [6:0] prev_coil = '0;
  logic       prev_run = 1'b0, prev_fault = 1'b0;
  logic [6:0] exp_coil[$];
  logic [5:0] exp_sns[$];

  always #2.5 clk = ~clk;

  coil_sample_seq #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .MAG_AW(5), .SNS_AW(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_stb(wr_stb), .host_wr_data(wr_data),
    .host_rd_stb(rd_stb), .host_rd_data(rd_data),
    .start_stb(go_stb), .stop_stb(halt_stb),
    .barrier_in(bar_in), .coil_en(coil_en),
    .running(running), .fault(fault),
    .mag_empty(mag_empty), .mag_full(mag_full),
    .sns_empty(sns_empty), .sns_full(sns_full), .sns_half(sns_half)
  );

  function automatic logic [5:0] pat(input int i);
    return 6'((i * 11 + 3) % 64);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each coil change against the scoreboard and times it
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_coil  <= '0;
      prev_run   <= 1'b0;
      prev_fault <= 1'b0;
      sidx       <= 0;
      bar_in     <= pat(0);
    end else begin
      prev_run   <= running;
      prev_fault <= fault;
      if (running && !prev_run) last_chg <= cyc;
      if (running && !prev_run) run_t <= cyc;
      if (fault && !prev_fault) fault_t <= cyc;
      if (coil_en != prev_coil) begin
        prev_coil <= coil_en;
        if (exp_coil.size() == 0) begin
          check(1'b0, "R3 unexpected coil change", int'(coil_en), 0);
        end else begin
          logic [6:0] e;
          e = exp_coil.pop_front();
          check(coil_en == e, "R3 coil value", int'(coil_en), int'(e));
          check(cyc - last_chg == DIV, "R2 tick spacing", cyc - last_chg, DIV);
        end
        last_chg <= cyc;
        sidx     <= sidx + 1;
        bar_in   <= pat(sidx + 1);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_coil.delete();
    exp_sns.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic hwr(input logic [7:0] d, input int hold);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    repeat (hold) @(negedge clk);
    wr_stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic hrd();
    @(negedge clk);
    rd_stb = 1'b1;
    repeat (2) @(negedge clk);
    rd_stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk);
    go_stb = 1'b1;
    repeat (2) @(negedge clk);
    go_stb = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    halt_stb = 1'b1;
    repeat (2) @(negedge clk);
    halt_stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_fault(input int limit);
    for (int i = 0; i < limit && !fault; i++) @(negedge clk);
  endtask

  task automatic drain_and_check(input int n);
    for (int i = 0; i < n; i++) begin
      logic [5:0] e;
      hrd();
      e = (exp_sns.size() != 0) ? exp_sns.pop_front() : 6'h3F;
      check(rd_data == e, "R8 sample order", int'(rd_data), int'(e));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ft;
    // ---------- run 1: full coil sweep, dry queue at the end
    do_reset();
    check(coil_en == 0 && !running && !fault, "R1 outputs idle",
          int'({coil_en, running, fault}), 0);
    check(mag_empty && sns_empty && !mag_full && !sns_full && !sns_half, "R1 flags",
          int'({mag_empty, sns_empty, mag_full, sns_full, sns_half}), 5'b11000);

    hwr(8'h0E, 10);   // long hold: R10 must push once
    exp_coil.push_back(7'b1000000);
    for (int k = 6; k >= 1; k--) begin
      hwr(8'(2 * k), 2);
      exp_coil.push_back(7'(1 << (k - 1)));
    end
    hwr(8'h00, 2);
    exp_coil.push_back(7'b0000000);
    for (int i = 0; i < 9; i++) exp_sns.push_back(pat(i));

    check(!mag_empty, "R10 pushed", int'(mag_empty), 0);
    repeat (3 * DIV) @(negedge clk);
    check(exp_coil.size() == 8 && coil_en == 0, "R2 idle before start",
          exp_coil.size(), 8);

    do_start();
    wait_fault(20 * DIV);
    do_stop();
    check(exp_coil.size() == 0, "R3 all commands applied once", exp_coil.size(), 0);
    check(fault_t - last_chg == DIV, "R6 dry queue fault on tick", fault_t - last_chg, DIV);
    check(!running && coil_en == 0, "R11 stopped", int'({running, coil_en}), 0);
    check(sns_half && !sns_full, "R9 half flag at 9 of 16",
          int'({sns_half, sns_full}), 2'b10);
    repeat (3 * DIV) @(negedge clk);
    drain_and_check(9);
    check(sns_empty, "R11 no samples after stop", int'(sns_empty), 1);
    hrd();
    check(rd_data == pat(8) && sns_empty, "R12 empty read ignored",
          int'(rd_data), int'(pat(8)));
    check(fault, "R7 fault sticky", int'(fault), 1);

    // ---------- run 2: reserved code
    do_reset();
    hwr(8'h02, 2);
    hwr(8'h05, 2);
    hwr(8'h04, 2);
    exp_coil.push_back(7'b0000001);
    exp_coil.push_back(7'b0000000);
    do_start();
    wait_fault(10 * DIV);
    @(negedge clk);
    @(negedge clk);
    check(fault_t == last_chg && exp_coil.size() == 0, "R5 reserved code dark and fault",
          fault_t - last_chg, 0);
    repeat (2 * DIV) @(negedge clk);
    check(coil_en == 0 && fault, "R7 valid code after fault stays dark",
          int'(coil_en), 0);
    do_stop();

    // ---------- run 3: sample overflow
    do_reset();
    for (int i = 0; i < 32; i++) hwr(8'h00, 2);
    check(mag_full, "R10 full flag", int'(mag_full), 1);
    for (int i = 0; i < 16; i++) exp_sns.push_back(pat(0));
    do_start();
    for (int i = 0; i < 40 * DIV && !sns_full; i++) @(negedge clk);
    ft = cyc;
    check(sns_full && !fault, "R9 full without fault", int'({sns_full, fault}), 2'b10);
    wait_fault(3 * DIV);
    check(cyc - ft == DIV, "R9 overflow fault next tick", cyc - ft, DIV);
    do_stop();
    drain_and_check(16);
    check(sns_empty, "R9 dropped sample not stored", int'(sns_empty), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule